// File: doc/BRIEF.md
# UART Receive Interrupt Logic

This block is the interrupt and register-access part of a serial receiver. A deserializer upstream hands over one byte at a time on a valid strobe. The block keeps the most recent byte in a receive holding register and marks it as waiting for the processor. If software has set the receive-enable bit in the enable register, the block raises an interrupt request towards an interrupt controller. The request stays high until the processor reads the byte through the register port. Software does not have to use the value it reads.

The processor reaches the block through a byte-wide register port:

| Offset | Access | Contents |
|--------|--------|----------|
| 0 | read | the received byte |
| 1 | read/write | the enable register |
| 2 | read | an identification byte |

Read data is registered. It appears on `reg_rdata` in the cycle after the read strobe and holds its value until the next read.

The receive input has no back-pressure. The block accepts a byte in every cycle that `rx_valid` is high. If a byte arrives while the previous one is still unread, the new byte replaces the old one and an overrun flag is set.

Top module: `uart_rx_irq`

## Requirements
- R1: After reset the enable register reads 0, no byte is pending and `irq` is low. A read at offset 2 returns 8'h01.
- R2: `irq` is high only while a byte is pending and bit 0 of the enable register is 1. Bits 7:1 of the enable register are stored and read back at offset 1, but they never affect `irq`.
- R3: A cycle with `rx_valid` high stores `rx_data` and marks it pending. With the enable bit set, `irq` is high from the following cycle.
- R4: A read at offset 0 returns the stored byte on `reg_rdata` in the next cycle and clears the pending mark, so `irq` is low from the next cycle. This holds even when software discards the value.
- R5: Writing 0 to bit 0 of the enable register drops `irq` in the next cycle. The byte stays stored and pending, and writing 1 again raises `irq` in the next cycle.
- R6: A byte that arrives while a byte is pending, and in a cycle without a read at offset 0, overwrites the stored byte and sets the overrun flag.
- R7: A read at offset 2 returns an identification byte. Bit 0 is 0 when a receive interrupt is active and 1 otherwise. Bit 1 is the overrun flag. Bits 7:2 are 0. The read clears the overrun flag unless an overrun is set in the same cycle.
- R8: When a byte arrives in the same cycle as a read at offset 0, the read returns the older byte. The new byte is stored and stays pending, and no overrun is flagged.
- R9: Reads at offsets other than 0, 1 and 2 return 0. Writes to any offset other than 1 change no state.
- R10: Back-to-back bytes on consecutive cycles are all accepted. The last one is the one held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| rx_valid | input | 1 | a byte is presented this cycle (always accepted) |
| rx_data | input | 8 | received byte |
| reg_rd | input | 1 | register read strobe |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, valid the cycle after a read |
| irq | output | 1 | receive interrupt request |

## Verification
The bench first runs directed sequences. These cover the reset state, a single byte with interrupts enabled and with them disabled, toggling the enable bit while a byte waits, a double arrival that overruns, an arrival in the same cycle as a read, and writes to read-only offsets. Each sequence separates one ordering question: which byte a read returns, and whether pending or overrun survives a collision.

A seeded random phase then mixes arrivals, reads at every offset and writes of random enable values, including writes of the upper bits. This separates the receive-enable bit from the stored-only bits. A model in the bench predicts `irq` in every cycle and `reg_rdata` after every read.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int OFS_RBUF  = 0;
  localparam int OFS_EN    = 1;
  localparam int OFS_ID    = 2;
  localparam int RX_EN_BIT = 0;

  typedef struct packed {
    logic rd_buf;
    logic rd_en;
    logic rd_id;
    logic wr_en;
  } reg_access_t;
endpackage

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  input  logic              ovr_clear,
  output logic [DATA_W-1:0] buf_data,
  output logic              pending,
  output logic              overrun
);
  logic ovr_set;
  assign ovr_set = in_valid && pending && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_data <= '0;
      pending  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (in_valid) buf_data <= in_data;
      if (in_valid)  pending <= 1'b1;
      else if (take) pending <= 1'b0;
      if (ovr_set)        overrun <= 1'b1;
      else if (ovr_clear) overrun <= 1'b0;
    end
  end

  AST_ARRIVAL_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (pending && buf_data == $past(in_data))); // R3
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_valid) |=> !pending); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pending && !take) |=> overrun); // R6
  AST_COLLIDE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && take && !overrun) |=> (pending && !overrun)); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clear && !(in_valid && pending && !take)) |=> !overrun); // R7
endmodule

// File: rtl/uart_rx_enable_reg.sv
module uart_rx_enable_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata;
  end

  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q)); // R9
endmodule

// File: rtl/uart_rx_read_mux.sv
module uart_rx_read_mux
  import uart_rx_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] buf_data,
  input  logic [DW-1:0] en_q,
  input  logic          irq_act,
  input  logic          overrun,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] id_val;
  logic [DW-1:0] sel;

  always_comb begin
    id_val    = '0;
    id_val[0] = !irq_act;
    id_val[1] = overrun;
  end

  always_comb begin
    case (addr)
      AW'(OFS_RBUF): sel = buf_data;
      AW'(OFS_EN):   sel = en_q;
      AW'(OFS_ID):   sel = id_val;
      default:       sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= sel;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr > AW'(OFS_ID)) |=> rdata == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R4
endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
  import uart_rx_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  reg_access_t acc;
  logic [DATA_W-1:0] buf_data;
  logic [DATA_W-1:0] en_q;
  logic pending;
  logic overrun;

  always_comb begin
    acc.rd_buf = reg_rd && reg_addr == ADDR_W'(OFS_RBUF);
    acc.rd_en  = reg_rd && reg_addr == ADDR_W'(OFS_EN);
    acc.rd_id  = reg_rd && reg_addr == ADDR_W'(OFS_ID);
    acc.wr_en  = reg_wr && reg_addr == ADDR_W'(OFS_EN);
  end

  uart_rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
    .take(acc.rd_buf), .ovr_clear(acc.rd_id),
    .buf_data(buf_data), .pending(pending), .overrun(overrun)
  );

  uart_rx_enable_reg #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(acc.wr_en), .wdata(reg_wdata), .en_q(en_q)
  );

  assign irq = pending && en_q[RX_EN_BIT];

  uart_rx_read_mux #(.DW(DATA_W), .AW(ADDR_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr),
    .buf_data(buf_data), .en_q(en_q), .irq_act(irq), .overrun(overrun),
    .rdata(reg_rdata)
  );

  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr_en && !reg_wdata[RX_EN_BIT]) |=> !irq); // R5
  AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd_buf && !rx_valid) |=> !irq); // R4
  AST_ARRIVE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && en_q[RX_EN_BIT] && !acc.wr_en) |=> irq); // R3
  AST_ENABLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr_en && reg_wdata[RX_EN_BIT] && pending && !acc.rd_buf) |=> irq); // R2
endmodule

// File: tb/tb_uart_rx_irq.sv
module tb_uart_rx_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic reg_rd = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] m_buf = '0, m_en = '0, m_rdata = '0;
  logic m_pend = 1'b0, m_ovr = 1'b0;

  uart_rx_irq dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic m_irq();
    return m_pend && m_en[0];
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_buf;
      3'd1: return m_en;
      3'd2: return {6'b0, m_ovr, !m_irq()};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic rd,
                     input logic wr, input logic [2:0] a, input logic [7:0] wd,
                     input string tag);
    logic ovr_set;
    rx_valid = v; rx_data = d; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    ovr_set = v && m_pend && !(rd && a == 3'd0);
    if (rd) m_rdata = m_read(a);
    if (v) begin m_buf = d; m_pend = 1'b1; end
    else if (rd && a == 3'd0) m_pend = 1'b0;
    if (ovr_set) m_ovr = 1'b1;
    else if (rd && a == 3'd2) m_ovr = 1'b0;
    if (wr && a == 3'd1) m_en = wd;
    @(negedge clk);
    rx_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
    check({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq()});
    if (rd) check({tag, " rdata"}, reg_rdata, m_rdata);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    cyc(0, 0, 1, 0, 3'd2, 0, "R1 id");
    check("R1 id value", reg_rdata, 8'h01);
    cyc(0, 0, 1, 0, 3'd1, 0, "R1 enable");
    // R2 byte without enable, upper bits only
    cyc(0, 0, 0, 1, 3'd1, 8'hFE, "R2 upper bits");
    cyc(1, 8'h5A, 0, 0, 0, 0, "R2 no enable");
    cyc(0, 0, 1, 0, 3'd1, 0, "R2 readback");
    cyc(0, 0, 1, 0, 3'd0, 0, "R4 discard read");
    // R3 enable then byte
    cyc(0, 0, 0, 1, 3'd1, 8'h01, "R3 enable");
    cyc(1, 8'hC3, 0, 0, 0, 0, "R3 arrival");
    check("R3 irq high", {7'b0, irq}, 8'h01);
    // R5 toggle enable with pending
    cyc(0, 0, 0, 1, 3'd1, 8'h00, "R5 disable");
    check("R5 irq low", {7'b0, irq}, 8'h00);
    cyc(0, 0, 0, 1, 3'd1, 8'h01, "R5 reenable");
    check("R5 irq back", {7'b0, irq}, 8'h01);
    cyc(0, 0, 1, 0, 3'd0, 0, "R4 read byte");
    check("R4 data", reg_rdata, 8'hC3);
    // R6/R7 overrun
    cyc(1, 8'h11, 0, 0, 0, 0, "R6 first");
    cyc(1, 8'h22, 0, 0, 0, 0, "R6 second");
    cyc(0, 0, 1, 0, 3'd2, 0, "R7 id with overrun");
    check("R7 id overrun", reg_rdata, 8'h02);
    cyc(0, 0, 1, 0, 3'd2, 0, "R7 overrun cleared");
    check("R7 id cleared", reg_rdata, 8'h00);
    // R8 collision
    cyc(1, 8'h77, 1, 0, 3'd0, 0, "R8 collide");
    check("R8 old byte", reg_rdata, 8'h22);
    cyc(0, 0, 1, 0, 3'd0, 0, "R8 new byte");
    check("R8 new kept", reg_rdata, 8'h77);
    // R9 ignored writes and unmapped reads
    cyc(0, 0, 0, 1, 3'd0, 8'hAA, "R9 write rbuf");
    cyc(0, 0, 0, 1, 3'd2, 8'hFF, "R9 write id");
    cyc(0, 0, 1, 0, 3'd0, 0, "R9 rbuf unchanged");
    cyc(0, 0, 1, 0, 3'd5, 0, "R9 unmapped");
    // R10 back-to-back
    for (int i = 0; i < 4; i++) cyc(1, 8'(8'h30 + i), 0, 0, 0, 0, "R10 stream");
    cyc(0, 0, 1, 0, 3'd0, 0, "R10 last held");
    check("R10 last byte", reg_rdata, 8'h33);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic v;
      op = int'($urandom % 8);
      v = ($urandom % 3) == 0;
      case (op)
        0, 1: cyc(v, 8'($urandom), 1, 0, 3'($urandom % 3), 0, "R2 random read");
        2:    cyc(v, 8'($urandom), 1, 0, 3'($urandom), 0, "R9 random read");
        3:    cyc(v, 8'($urandom), 0, 1, 3'd1, 8'($urandom), "R5 random enable");
        4:    cyc(v, 8'($urandom), 0, 1, 3'($urandom), 8'($urandom), "R9 random write");
        default: cyc(v, 8'($urandom), 0, 0, 0, 0, "R3 random idle");
      endcase
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule